// File: doc/BRIEF.md
# Cascadable Bidirectional Line Data Capture

This block collects one display line of gray-scale values for a column driver that sits in a chain with other identical drivers. On each clock it takes a 36-bit word made of six 6-bit dot values and writes them into a line register of 384 entries. A one-hot pointer with 64 slots selects where each word goes. The line is full after 64 data clocks.

A direction input sets which start pin is the input and which one drives the next driver in the chain. It also sets whether the line fills upward from entry 0 or downward from entry 383. On the 64th clock after its start pulse, the block sends a one-clock pulse on the chain output. Two inversion controls can complement the incoming dots: one for each half of the data word. A rising edge on the strobe input stops a capture that is in progress.

Top module: `cascade_line_capture`

## Requirements
- R1: Dot g of data_i (bits 6g+5..6g, bit 6g is the LSB) is stored in entry 6s+g on the s-th data clock (s = 0..63) after the start edge when dir_right_i = 1. The start edge is the clock at which the start input is seen high after being low. Entry e is line_o[6e+5:6e].
- R2: When dir_right_i = 0, dot g of data clock s is stored in entry 383-(6s+g), so dot 0 of the first data clock lands in entry 383.
- R3: When dir_right_i = 1, start_l_i is the start input and start_r_o is the chain output. When dir_right_i = 0, start_r_i is the start input and start_l_o is the chain output. The start pin that is not selected is ignored, and the chain output that is not selected stays low.
- R4: A start input held high for several clocks counts only at its first high clock. The clocks after it are ordinary data clocks.
- R5: The selected chain output is high for exactly one clock, after the 64th rising edge that follows the start edge, and low at all other times.
- R6: Once 64 data clocks are stored, further data_i does not change the line register. Capture stays halted until the next start edge; the internal run state ends at the 66th clock after the start edge.
- R7: A rising edge of strobe_i clears the pointer. Data on that clock and on later clocks is not stored, and no chain pulse follows, until a new start edge. A new start must come at least 2 clocks after the strobe edge.
- R8: When inv_a_i = 1 on a data clock, dots 0..2 are stored bit-complemented. When inv_b_i = 1, dots 3..5 are stored bit-complemented. When a control is 0, its dots are stored unchanged.
- R9: A start edge during a capture restarts the pointer at slot 0. Data on that clock is not stored, and the chain pulse timing restarts from this edge.
- R10: Reset (rst_ni = 0) clears the pointer, the run state and the chain outputs. The line register keeps its contents, and no data is stored after reset until a start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dir_right_i | input | 1 | 1: fill upward, start on left pin; 0: fill downward, start on right pin |
| start_l_i | input | 1 | Left start pin, input side |
| start_r_i | input | 1 | Right start pin, input side |
| start_l_o | output | 1 | Left start pin, chain output side |
| start_r_o | output | 1 | Right start pin, chain output side |
| strobe_i | input | 1 | Line strobe; its rising edge clears the pointer |
| inv_a_i | input | 1 | Complement dots 0..2 |
| inv_b_i | input | 1 | Complement dots 3..5 |
| data_i | input | 36 | Six 6-bit dot values |
| line_o | output | 2304 | Line register, entry e at bits 6e+5..6e |

## Verification
A pointer that is off by one slot, or that runs in the wrong direction, shows in line_o as soon as the line is full. Every entry is compared against a model built from the requirements, so a single misplaced dot is reported. A sequencer count that is wrong moves the chain pulse, which is checked on every clock of a capture. A halt or strobe clear that does not take effect lets stray data overwrite entries that the model expects to keep, and this shows when the line is next compared. A restart that is not taken shifts every later dot and moves the chain pulse, so both show in the same line.

// File: rtl/lcap_pkg.sv
package lcap_pkg;
  localparam int unsigned DOT_W_D = 6;
  localparam int unsigned DOTS_D  = 6;
  localparam int unsigned OUTS_D  = 384;
  localparam int unsigned TAIL_D  = 2;   // clocks after the last slot before halt
endpackage

// File: rtl/lcap_seq.sv
module lcap_seq #(
  parameter int unsigned SLOTS = 64,
  parameter int unsigned TAIL  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dir_right_i,
  input  logic start_l_i,
  input  logic start_r_i,
  input  logic strobe_i,
  output logic load_o,
  output logic clear_o,
  output logic run_o,
  output logic casc_o
);
  localparam int unsigned HALT = SLOTS + TAIL;
  localparam int unsigned CW   = $clog2(HALT + 1);
  localparam logic [CW-1:0] CASC_AT = CW'(SLOTS);
  localparam logic [CW-1:0] HALT_AT = CW'(HALT);

  logic          start_sel, start_q, strobe_q;
  logic          run_q, casc_q;
  logic [CW-1:0] cnt_q;

  assign start_sel = dir_right_i ? start_l_i : start_r_i;
  assign clear_o   = strobe_i & ~strobe_q;
  assign load_o    = start_sel & ~start_q & ~clear_o;
  assign run_o     = run_q;
  assign casc_o    = casc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q  <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      start_q  <= start_sel;
      strobe_q <= strobe_i;
    end
  end

  // cnt_q holds the number of edges since the start edge, plus one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      casc_q <= 1'b0;
    end else if (clear_o) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      casc_q <= 1'b0;
    end else if (load_o) begin
      run_q  <= 1'b1;
      cnt_q  <= CW'(1);
      casc_q <= 1'b0;
    end else begin
      casc_q <= run_q && (cnt_q == CASC_AT);
      if (run_q) begin
        if (cnt_q == HALT_AT) begin
          run_q <= 1'b0;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/lcap_ptr.sv
module lcap_ptr #(
  parameter int unsigned SLOTS = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             clear_i,
  input  logic             run_i,
  output logic [SLOTS-1:0] ptr_o,
  output logic [SLOTS-1:0] we_o
);
  logic [SLOTS-1:0] ptr_q;

  assign ptr_o = ptr_q;
  assign we_o  = (load_i || clear_i || !run_i) ? '0 : ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ptr_q <= '0;
    else if (clear_i)   ptr_q <= '0;
    else if (load_i)    ptr_q <= SLOTS'(1);
    else if (!run_i)    ptr_q <= '0;
    else                ptr_q <= ptr_q << 1;
  end
endmodule

// File: rtl/lcap_invert.sv
module lcap_invert #(
  parameter int unsigned DOT_W = 6,
  parameter int unsigned DOTS  = 6
) (
  input  logic [DOT_W*DOTS-1:0] data_i,
  input  logic                  inv_a_i,
  input  logic                  inv_b_i,
  output logic [DOT_W*DOTS-1:0] data_o
);
  localparam int unsigned HALF = DOTS / 2;

  for (genvar g = 0; g < DOTS; g++) begin : g_dot
    logic inv;
    if (g < HALF) begin : g_a
      assign inv = inv_a_i;
    end else begin : g_b
      assign inv = inv_b_i;
    end
    assign data_o[g*DOT_W +: DOT_W] = data_i[g*DOT_W +: DOT_W] ^ {DOT_W{inv}};
  end
endmodule

// File: rtl/lcap_line.sv
module lcap_line #(
  parameter int unsigned DOT_W = 6,
  parameter int unsigned DOTS  = 6,
  parameter int unsigned OUTS  = 384,
  localparam int unsigned SLOTS = OUTS / DOTS
) (
  input  logic                  clk_i,
  input  logic                  dir_right_i,
  input  logic [SLOTS-1:0]      we_i,
  input  logic [DOT_W*DOTS-1:0] dots_i,
  output logic [DOT_W*OUTS-1:0] line_o
);
  for (genvar j = 0; j < OUTS; j++) begin : g_ent
    localparam int unsigned SR = j / DOTS;
    localparam int unsigned GR = j % DOTS;
    localparam int unsigned SL = (OUTS - 1 - j) / DOTS;
    localparam int unsigned GL = (OUTS - 1 - j) % DOTS;
    logic [DOT_W-1:0] ent_q;

    always_ff @(posedge clk_i) begin
      if (dir_right_i && we_i[SR])
        ent_q <= dots_i[GR*DOT_W +: DOT_W];
      else if (!dir_right_i && we_i[SL])
        ent_q <= dots_i[GL*DOT_W +: DOT_W];
    end
    assign line_o[j*DOT_W +: DOT_W] = ent_q;
  end
endmodule

// File: rtl/cascade_line_capture.sv
module cascade_line_capture
  import lcap_pkg::*;
#(
  parameter int unsigned DOT_W = DOT_W_D,
  parameter int unsigned DOTS  = DOTS_D,
  parameter int unsigned OUTS  = OUTS_D,
  parameter int unsigned TAIL  = TAIL_D
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  dir_right_i,
  input  logic                  start_l_i,
  input  logic                  start_r_i,
  output logic                  start_l_o,
  output logic                  start_r_o,
  input  logic                  strobe_i,
  input  logic                  inv_a_i,
  input  logic                  inv_b_i,
  input  logic [DOT_W*DOTS-1:0] data_i,
  output logic [DOT_W*OUTS-1:0] line_o
);
  localparam int unsigned SLOTS = OUTS / DOTS;

  logic             load, clear, run, casc;
  logic [SLOTS-1:0] ptr, we;
  logic [DOT_W*DOTS-1:0] dots;

  lcap_seq #(.SLOTS(SLOTS), .TAIL(TAIL)) i_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .dir_right_i(dir_right_i),
    .start_l_i(start_l_i), .start_r_i(start_r_i), .strobe_i(strobe_i),
    .load_o(load), .clear_o(clear), .run_o(run), .casc_o(casc)
  );

  lcap_ptr #(.SLOTS(SLOTS)) i_ptr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .clear_i(clear),
    .run_i(run), .ptr_o(ptr), .we_o(we)
  );

  lcap_invert #(.DOT_W(DOT_W), .DOTS(DOTS)) i_inv (
    .data_i(data_i), .inv_a_i(inv_a_i), .inv_b_i(inv_b_i), .data_o(dots)
  );

  lcap_line #(.DOT_W(DOT_W), .DOTS(DOTS), .OUTS(OUTS)) i_line (
    .clk_i(clk_i), .dir_right_i(dir_right_i), .we_i(we),
    .dots_i(dots), .line_o(line_o)
  );

  assign start_r_o = casc & dir_right_i;
  assign start_l_o = casc & ~dir_right_i;
endmodule

// File: rtl/lcap_checker.sv
module lcap_checker #(
  parameter int unsigned SLOTS = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [SLOTS-1:0] ptr,
  input logic             load,
  input logic             clear,
  input logic             start_l_o,
  input logic             start_r_o
);
  p_ptr_onehot_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ptr));

  p_ptr_advance_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr != '0 && !ptr[SLOTS-1] && !load && !clear) |=> ptr == ($past(ptr) << 1));

  p_start_slot0_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> (ptr[0] && $countones(ptr) == 1));

  p_strobe_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear |=> (ptr == '0 && !start_l_o && !start_r_o));

  p_casc_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_l_o || start_r_o) |=> !(start_l_o || start_r_o));

  p_casc_idle_ptr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_l_o || start_r_o) |-> ptr == '0);

  p_casc_pins_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_l_o && start_r_o));
endmodule

bind cascade_line_capture lcap_checker i_lcap_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .ptr(ptr), .load(load), .clear(clear),
  .start_l_o(start_l_o), .start_r_o(start_r_o)
);

// File: tb/test_cascade_line_capture.sv
`timescale 1ns/1ps
module test_cascade_line_capture;
  localparam int W = 6, D = 6, N = 384, S = 64;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic dir_right = 1'b1, st_l = 1'b0, st_r = 1'b0, strobe = 1'b0;
  logic inv_a = 1'b0, inv_b = 1'b0;
  logic [W*D-1:0] data = '0;
  logic st_l_o, st_r_o;
  logic [W*N-1:0] line;

  int total = 0, bad = 0;
  int expv [N];

  typedef struct { int idx; int val; string tag; } item_t;
  item_t q [$];

  always #2 clk = ~clk;

  cascade_line_capture i_cascade_line_capture (
    .clk_i(clk), .rst_ni(rst_ni), .dir_right_i(dir_right),
    .start_l_i(st_l), .start_r_i(st_r), .start_l_o(st_l_o), .start_r_o(st_r_o),
    .strobe_i(strobe), .inv_a_i(inv_a), .inv_b_i(inv_b), .data_i(data),
    .line_o(line)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // monitor: pops expected entries and compares them with line_o
  initial forever begin
    @(negedge clk);
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      chk($sformatf("%s entry %0d", it.tag, it.idx),
          int'(line[it.idx*W +: W]), it.val);
    end
  end

  task automatic check_all(input string tag);
    for (int e = 0; e < N; e++) q.push_back('{e, expv[e], tag});
    while (q.size() > 0) @(negedge clk);
  endtask

  function automatic int dotv(int seed, int s, int g);
    return (seed * 7 + s * 5 + g * 11 + s * g) & 63;
  endfunction

  task automatic casc_chk(input string tag, input bit exp_hi);
    chk({tag, " casc sel"}, dir_right ? int'(st_r_o) : int'(st_l_o), int'(exp_hi));
    chk("R3 casc other", dir_right ? int'(st_l_o) : int'(st_r_o), 0);
  endtask

  task automatic set_start(input bit v);
    if (dir_right) st_l = v; else st_r = v;
  endtask

  task automatic set_other(input bit v);
    if (dir_right) st_r = v; else st_l = v;
  endtask

  task automatic junk(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      casc_chk(tag, 1'b0);
      data = {6{6'(k * 13 + 5)}} ^ 36'h5A5A5A5A5;
      inv_a = k[0]; inv_b = k[1];
      @(posedge clk);
    end
  endtask

  // driver: start edge, nslots data clocks, model update, cascade checks
  task automatic drive_line(input bit dir, input bit ia, input bit ib,
                            input int seed, input int nslots, input int hold,
                            input bit noise, input int tail);
    @(negedge clk);
    dir_right = dir;
    set_start(1'b1);
    @(posedge clk);
    for (int s = 0; s < nslots; s++) begin
      @(negedge clk);
      if (s >= 1) casc_chk("R5 early", 1'b0);
      if (s >= hold - 1) set_start(1'b0);
      set_other(noise && s == 30);
      inv_a = ia; inv_b = ib;
      for (int g = 0; g < D; g++) begin
        int v, e;
        v = dotv(seed, s, g);
        data[g*W +: W] = 6'(v);
        if ((g < 3 && ia) || (g >= 3 && ib)) v = v ^ 63;
        e = dir ? (6 * s + g) : (N - 1 - (6 * s + g));
        expv[e] = v;
      end
      @(posedge clk);
    end
    set_start(1'b0);
    if (nslots == S) begin
      @(negedge clk);
      casc_chk("R5 pulse", 1'b1);
      data = ~data;
      @(posedge clk);
      junk(tail, "R6 tail");
    end
  endtask

  initial begin
    for (int e = 0; e < N; e++) expv[e] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 reset casc l", int'(st_l_o), 0);
    chk("R10 reset casc r", int'(st_r_o), 0);
    rst_ni = 1'b1;

    drive_line(1'b1, 1'b0, 1'b0, 1, S, 1, 1'b0, 10); check_all("R1 right");
    drive_line(1'b0, 1'b0, 1'b0, 2, S, 1, 1'b0, 10); check_all("R2 left");
    drive_line(1'b1, 1'b1, 1'b0, 3, S, 1, 1'b0, 4);  check_all("R8 inv a");
    drive_line(1'b0, 1'b0, 1'b1, 4, S, 1, 1'b0, 4);  check_all("R8 inv b");
    drive_line(1'b1, 1'b0, 1'b0, 5, S, 3, 1'b0, 4);  check_all("R4 held start");
    drive_line(1'b0, 1'b1, 1'b1, 6, S, 1, 1'b1, 4);  check_all("R3 noise pin");
    junk(20, "R6 halted");                            check_all("R6 halted");

    // restart mid-capture
    drive_line(1'b1, 1'b0, 1'b0, 7, 20, 1, 1'b0, 0);
    drive_line(1'b1, 1'b0, 1'b0, 8, S, 1, 1'b0, 4);  check_all("R9 restart");

    // strobe mid-capture
    drive_line(1'b0, 1'b0, 1'b0, 9, 10, 1, 1'b0, 0);
    @(negedge clk); strobe = 1'b1; data = ~data; @(posedge clk);
    @(negedge clk); strobe = 1'b0; @(posedge clk);
    junk(70, "R7 after strobe");                      check_all("R7 strobe");

    // reset mid-capture
    drive_line(1'b1, 1'b0, 1'b0, 10, 10, 1, 1'b0, 0);
    @(negedge clk); rst_ni = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R10 casc l", int'(st_l_o), 0);
    chk("R10 casc r", int'(st_r_o), 0);
    rst_ni = 1'b1;
    junk(70, "R10 after reset");                      check_all("R10 reset");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog act=1 exp=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule